// File: doc/BRIEF.md
# Debug abstract register-access engine

This block is the abstract-command engine of a debug module serving one halted hart that has no program buffer. A debug transport sends it register-level accesses (a 7-bit address, 32 bits of data and a 2-bit operation). Through these accesses the debugger loads the two data words, issues access-register commands, and reads back the status word. Because there is no program buffer, every GPR or CSR access the debugger needs must be done as an abstract command. The block decodes each command and forwards the access to the hart over a simple request/valid port. It then places any read result in the data words.

Errors are recorded in a sticky three-bit error code in the status word. The code keeps three cases apart. A command the block cannot perform reads back as 2. A register access that the hart faults reads back as 3. A write that arrives while a command is still running reads back as 1. The debugger clears the code by writing ones to its bits.

Top module: `dbg_abs_engine`

## Requirements
- R1: After reset the status word (address 0x16) reads 0x00000802, both data words read 0, and hart_req is low.
- R2: The status word holds the data-word count 2 in bits 3:0, the error code in bits 10:8, a constant 1 in bit 11 and busy in bit 12. All other bits read 0, so busy with no error reads 0x1802.
- R3: dmi_op 1 is a read and 2 is a write; 0 does nothing. data0 is at 0x04, data1 at 0x05, the status word at 0x16 and the command at 0x17. The read value appears on dmi_rdata in the cycle after the read is sampled. An unmapped address reads 0.
- R4: The command word is decoded as follows: bits 31:24 are the command type (0 = register access), bit 23 is reserved, bits 22:20 give the size (2 = 32-bit, 3 = 64-bit), bit 19 is post-increment, bit 18 is post-execute, bit 17 is transfer, bit 16 is write, and bits 15:0 are the register number. A 32-bit read puts the value in data0 and leaves data1 unchanged.
- R5: A 64-bit read puts the low word in data0 and the high word in data1.
- R6: A write command sends hart_wdata = {data1, data0} with hart_wide high for size 3, and {32'h0, data0} with hart_wide low for size 2. The data words themselves are left unchanged.
- R7: Some commands cannot be performed: a nonzero type, a set reserved bit, post-execute, post-increment, or (with transfer set) a size other than 2 or 3 or a register number of 0x1020 or above. Such a command sets the error code to 2, makes no hart request and changes no data word.
- R8: A hart completion with hart_fault high sets the error code to 3 and leaves both data words unchanged.
- R9: Busy is set from command acceptance until the hart completes. A write to the command or data words while busy is dropped and sets the error code to 1.
- R10: While the error code is nonzero, a command write is ignored: no hart request is made and no data word changes.
- R11: Writing the status word clears each error-code bit for which bit 8+i of the written data is 1. For example, writing 0x100 turns code 3 into code 2.
- R12: A command with transfer clear and otherwise valid fields completes without a hart request and without error.
- R13: hart_req stays high, with a stable register number, until hart_valid is sampled. It drops in the cycle after hart_valid, and only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmi_valid | input | 1 | Register access present this cycle |
| dmi_addr | input | 7 | Register address |
| dmi_op | input | 2 | 0 none, 1 read, 2 write |
| dmi_wdata | input | 32 | Write data |
| dmi_rdata | output | 32 | Read data, registered |
| hart_req | output | 1 | Hart access request, held until hart_valid |
| hart_regno | output | 16 | Register number of the access |
| hart_we | output | 1 | 1 = write access |
| hart_wide | output | 1 | 1 = 64-bit access |
| hart_wdata | output | 64 | Write value |
| hart_valid | input | 1 | Hart completion, single cycle |
| hart_fault | input | 1 | Access faulted, valid with hart_valid |
| hart_rdata | input | 64 | Read value, valid with hart_valid |

## Verification
The checker watches these rules on every cycle:
- the hart request handshake: the request is held, its register number stays stable, and it drops after completion;
- a faulting completion turns a clear error code into 3;
- a write made while busy turns a clear code into 1;
- no request starts while an error is pending;
- writing all ones to the error field clears it.

Other behaviour can only be shown by the bench's scenarios, which compare the data words and the status word against expected values. This covers the word placement of 32-bit and 64-bit reads and writes, the correct split between unsupported commands and faulting registers, partial clearing of the error code, the dropping of data writes made while busy, and the absence of any hart request for rejected or non-transfer commands.

// File: rtl/dbg_abs_pkg.sv
package dbg_abs_pkg;
    localparam int DMI_AW    = 7;
    localparam int WORD_W    = 32;
    localparam int REGNO_W   = 16;
    localparam int GPR_COUNT = 32;
    localparam int WIDE_W    = 2 * WORD_W;

    localparam logic [DMI_AW-1:0] ADR_DATA0 = 7'h04;
    localparam logic [DMI_AW-1:0] ADR_DATA1 = 7'h05;
    localparam logic [DMI_AW-1:0] ADR_STAT  = 7'h16;
    localparam logic [DMI_AW-1:0] ADR_CMD   = 7'h17;

    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    localparam logic [2:0] SZ_32 = 3'd2;
    localparam logic [2:0] SZ_64 = 3'd3;

    localparam logic [REGNO_W-1:0] GPR_BASE = 16'h1000;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_BUSY  = 3'd1,
        ERR_UNSUP = 3'd2,
        ERR_EXC   = 3'd3
    } err_code_e;

    typedef struct packed {
        logic [7:0]         kind;
        logic               rsvd;
        logic [2:0]         size;
        logic               postinc;
        logic               postexec;
        logic               transfer;
        logic               write;
        logic [REGNO_W-1:0] regno;
    } acc_cmd_t;

    typedef struct packed {
        logic [REGNO_W-1:0] regno;
        logic               we;
        logic               wide;
    } hart_op_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    function automatic logic regno_supported(input logic [REGNO_W-1:0] r);
        return r < (GPR_BASE + REGNO_W'(GPR_COUNT));
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic busy,
                                                      input logic [2:0] err);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[3:0]   = 4'd2;
        w[10:8]  = err;
        w[11]    = 1'b1;
        w[12]    = busy;
        return w;
    endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_abs_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output logic              unsup,
    output logic              xfer,
    output hart_op_t          op
);
    acc_cmd_t c;
    logic     size_ok;
    logic     opt_bad;

    always_comb begin
        c        = acc_cmd_t'(cmd_word);
        size_ok  = (c.size == SZ_32) || (c.size == SZ_64);
        opt_bad  = (c.kind != 8'd0) || c.rsvd || c.postexec || c.postinc;
        unsup    = opt_bad || (c.transfer && (!size_ok || !regno_supported(c.regno)));
        xfer     = c.transfer;
        op.regno = c.regno;
        op.we    = c.write;
        op.wide  = (c.size == SZ_64);
    end
endmodule

// File: rtl/dbg_hart_seq.sv
module dbg_hart_seq
    import dbg_abs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  hart_op_t          op_in,
    input  logic [WORD_W-1:0] data0,
    input  logic [WORD_W-1:0] data1,
    output logic              busy,
    output logic              hart_req,
    output hart_op_t          op_out,
    output logic [WIDE_W-1:0] wdata_out,
    input  logic              hart_valid,
    input  logic              hart_fault,
    output logic              done,
    output logic              done_fault
);
    seq_state_e state_q;
    hart_op_t   op_q;
    logic [WIDE_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            op_q    <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        op_q    <= op_in;
                        wdata_q <= op_in.wide ? {data1, data0}
                                              : {{WORD_W{1'b0}}, data0};
                        state_q <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (hart_valid) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == SEQ_WAIT);
    assign hart_req   = busy;
    assign op_out     = op_q;
    assign wdata_out  = wdata_q;
    assign done       = busy && hart_valid;
    assign done_fault = hart_fault;
endmodule

// File: rtl/dbg_dmi_regs.sv
module dbg_dmi_regs
    import dbg_abs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dmi_valid,
    input  logic [DMI_AW-1:0] dmi_addr,
    input  logic [1:0]        dmi_op,
    input  logic [WORD_W-1:0] dmi_wdata,
    output logic [WORD_W-1:0] dmi_rdata,
    input  logic              dec_unsup,
    input  logic              dec_xfer,
    input  logic              busy,
    input  logic              done,
    input  logic              done_fault,
    input  hart_op_t          done_op,
    input  logic [WIDE_W-1:0] done_rdata,
    output logic              start,
    output logic [WORD_W-1:0] data0,
    output logic [WORD_W-1:0] data1,
    output logic [2:0]        cmderr
);
    logic              wr, rd, wr_cmd, wr_data, busy_viol, unsup_hit;
    logic [2:0]        err_d;
    logic [WORD_W-1:0] d0_q, d1_q, rdata_q;
    logic [2:0]        err_q;

    always_comb begin
        wr        = dmi_valid && (dmi_op == OP_WRITE);
        rd        = dmi_valid && (dmi_op == OP_READ);
        wr_cmd    = wr && (dmi_addr == ADR_CMD);
        wr_data   = wr && ((dmi_addr == ADR_DATA0) || (dmi_addr == ADR_DATA1));
        busy_viol = busy && (wr_cmd || wr_data);
        unsup_hit = wr_cmd && !busy && dec_unsup;
        start     = wr_cmd && !busy && (err_q == ERR_NONE) && !dec_unsup && dec_xfer;

        err_d = err_q;
        if (wr && (dmi_addr == ADR_STAT)) begin
            err_d = err_q & ~dmi_wdata[10:8];
        end
        if (err_q == ERR_NONE) begin
            if (busy_viol) begin
                err_d = ERR_BUSY;
            end else if (unsup_hit) begin
                err_d = ERR_UNSUP;
            end else if (done && done_fault) begin
                err_d = ERR_EXC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d0_q  <= '0;
            d1_q  <= '0;
            err_q <= ERR_NONE;
        end else begin
            err_q <= err_d;
            if (done) begin
                if (!done_fault && !done_op.we) begin
                    d0_q <= done_rdata[WORD_W-1:0];
                    if (done_op.wide) begin
                        d1_q <= done_rdata[WIDE_W-1:WORD_W];
                    end
                end
            end else if (wr && !busy) begin
                if (dmi_addr == ADR_DATA0) d0_q <= dmi_wdata;
                if (dmi_addr == ADR_DATA1) d1_q <= dmi_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            case (dmi_addr)
                ADR_DATA0: rdata_q <= d0_q;
                ADR_DATA1: rdata_q <= d1_q;
                ADR_STAT:  rdata_q <= status_word(busy, err_q);
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign dmi_rdata = rdata_q;
    assign data0     = d0_q;
    assign data1     = d1_q;
    assign cmderr    = err_q;
endmodule

// File: rtl/dbg_abs_engine.sv
module dbg_abs_engine
    import dbg_abs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dmi_valid,
    input  logic [DMI_AW-1:0] dmi_addr,
    input  logic [1:0]        dmi_op,
    input  logic [WORD_W-1:0] dmi_wdata,
    output logic [WORD_W-1:0] dmi_rdata,
    output logic              hart_req,
    output logic [REGNO_W-1:0] hart_regno,
    output logic              hart_we,
    output logic              hart_wide,
    output logic [WIDE_W-1:0] hart_wdata,
    input  logic              hart_valid,
    input  logic              hart_fault,
    input  logic [WIDE_W-1:0] hart_rdata
);
    logic              dec_unsup, dec_xfer, start, busy, done, done_fault;
    logic [WORD_W-1:0] data0, data1;
    logic [2:0]        cmderr;
    hart_op_t          dec_op, cur_op;

    dbg_cmd_decode u_dec (
        .cmd_word (dmi_wdata),
        .unsup    (dec_unsup),
        .xfer     (dec_xfer),
        .op       (dec_op)
    );

    dbg_hart_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_in      (dec_op),
        .data0      (data0),
        .data1      (data1),
        .busy       (busy),
        .hart_req   (hart_req),
        .op_out     (cur_op),
        .wdata_out  (hart_wdata),
        .hart_valid (hart_valid),
        .hart_fault (hart_fault),
        .done       (done),
        .done_fault (done_fault)
    );

    dbg_dmi_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .dmi_valid  (dmi_valid),
        .dmi_addr   (dmi_addr),
        .dmi_op     (dmi_op),
        .dmi_wdata  (dmi_wdata),
        .dmi_rdata  (dmi_rdata),
        .dec_unsup  (dec_unsup),
        .dec_xfer   (dec_xfer),
        .busy       (busy),
        .done       (done),
        .done_fault (done_fault),
        .done_op    (cur_op),
        .done_rdata (hart_rdata),
        .start      (start),
        .data0      (data0),
        .data1      (data1),
        .cmderr     (cmderr)
    );

    assign hart_regno = cur_op.regno;
    assign hart_we    = cur_op.we;
    assign hart_wide  = cur_op.wide;
endmodule

// File: rtl/dbg_abs_checker.sv
module dbg_abs_checker (
    input logic        clk,
    input logic        rst,
    input logic        dmi_valid,
    input logic [6:0]  dmi_addr,
    input logic [1:0]  dmi_op,
    input logic [31:0] dmi_wdata,
    input logic        hart_req,
    input logic [15:0] hart_regno,
    input logic        hart_valid,
    input logic        hart_fault,
    input logic        busy,
    input logic [2:0]  cmderr
);
    logic wr_any;
    assign wr_any = dmi_valid && (dmi_op == 2'd2);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        hart_req && !hart_valid |=> hart_req);                                  // R13
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        hart_req && !hart_valid |=> $stable(hart_regno));                       // R13
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        hart_req && hart_valid |=> !hart_req);                                  // R13
    AST_FAULT_EXC: assert property (@(posedge clk) disable iff (rst)
        hart_req && hart_valid && hart_fault && cmderr == 3'd0
        && !(wr_any && (dmi_addr == 7'h17 || dmi_addr == 7'h04 || dmi_addr == 7'h05))
        |=> cmderr == 3'd3);                                                     // R8
    AST_BUSY_VIOL: assert property (@(posedge clk) disable iff (rst)
        wr_any && busy && cmderr == 3'd0 && dmi_addr == 7'h17 |=> cmderr == 3'd1); // R9
    AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        !hart_req && cmderr != 3'd0 |=> !hart_req);                             // R10
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        wr_any && dmi_addr == 7'h16 && dmi_wdata[10:8] == 3'b111 && !busy
        |=> cmderr == 3'd0);                                                     // R11
endmodule

bind dbg_abs_engine dbg_abs_checker u_chk (.*);

// File: tb/test_dbg_abs_engine.sv
module test_dbg_abs_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dmi_valid = 1'b0;
    logic [6:0]  dmi_addr = '0;
    logic [1:0]  dmi_op = '0;
    logic [31:0] dmi_wdata = '0;
    logic [31:0] dmi_rdata;
    logic        hart_req, hart_we, hart_wide;
    logic [15:0] hart_regno;
    logic [63:0] hart_wdata;
    logic        hart_valid = 1'b0;
    logic        hart_fault = 1'b0;
    logic [63:0] hart_rdata = '0;

    always #10 clk = ~clk;

    dbg_abs_engine i_dbg_abs_engine (.*);

    // hart model: answers LAT negedges after it sees a request
    localparam int LAT = 3;
    logic [63:0] gpr [32];
    logic [63:0] dcsr_v;
    int          cnt = 0;
    int          nreq = 0;

    always @(negedge clk) begin
        if (rst) begin
            hart_valid = 1'b0;
            cnt = 0;
        end else if (hart_valid) begin
            hart_valid = 1'b0;
            hart_fault = 1'b0;
            cnt = 0;
        end else if (hart_req) begin
            cnt++;
            if (cnt == LAT) begin
                nreq++;
                hart_valid = 1'b1;
                hart_fault = 1'b0;
                hart_rdata = '0;
                if (hart_regno >= 16'h1000 && hart_regno < 16'h1020) begin
                    if (hart_we) begin
                        if (hart_regno != 16'h1000) gpr[hart_regno[4:0]] = hart_wdata;
                    end else begin
                        hart_rdata = gpr[hart_regno[4:0]];
                    end
                end else if (hart_regno == 16'h07b0) begin
                    if (hart_we) dcsr_v = hart_wdata;
                    else hart_rdata = dcsr_v;
                end else begin
                    hart_fault = 1'b1;
                end
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dmi_wr(input logic [6:0] a, input logic [31:0] d);
        dmi_valid = 1'b1; dmi_op = 2'd2; dmi_addr = a; dmi_wdata = d;
        @(posedge clk); @(negedge clk);
        dmi_valid = 1'b0; dmi_op = 2'd0;
    endtask

    task automatic dmi_rd(input logic [6:0] a, output logic [31:0] d);
        dmi_valid = 1'b1; dmi_op = 2'd1; dmi_addr = a;
        @(posedge clk); @(negedge clk);
        dmi_valid = 1'b0; dmi_op = 2'd0;
        d = dmi_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 40; k++) begin
            dmi_rd(7'h16, s);
            if (!s[12]) break;
        end
    endtask

    function automatic logic [31:0] stat(input logic busy, input logic [2:0] e);
        return 32'h0000_0802 | (32'(e) << 8) | (32'(busy) << 12);
    endfunction

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] pre0;
        logic [31:0] pre1;
        logic [2:0]  err;
        logic [31:0] exp0;
        logic [31:0] exp1;
        logic        req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{32'h002207b0, 32'h0, 32'haaaa5555, 3'd0, 32'h40000003, 32'haaaa5555, 1'b1}, // R4 dcsr
        '{32'h00321008, 32'h0, 32'h0, 3'd0, 32'h00038220, 32'hffff8f80, 1'b1},        // R5 x8
        '{32'h00331009, 32'h11223344, 32'h55667788, 3'd0, 32'h11223344, 32'h55667788, 1'b1}, // R6 wide write
        '{32'h00321009, 32'h0, 32'h0, 3'd0, 32'h11223344, 32'h55667788, 1'b1},        // R6 readback
        '{32'h0023100a, 32'hdeadbeef, 32'h12345678, 3'd0, 32'hdeadbeef, 32'h12345678, 1'b1}, // R6 narrow write
        '{32'h0032100a, 32'h0, 32'h0, 3'd0, 32'hdeadbeef, 32'h0, 1'b1},               // R6 upper zero
        '{32'h002207b5, 32'h1, 32'h2, 3'd3, 32'h1, 32'h2, 1'b1},                      // R8 fault
        '{32'h002607b0, 32'h3, 32'h4, 3'd2, 32'h3, 32'h4, 1'b0},                      // R7 postexec
        '{32'h004207b0, 32'h5, 32'h6, 3'd2, 32'h5, 32'h6, 1'b0},                      // R7 size
        '{32'h01000000, 32'h7, 32'h8, 3'd2, 32'h7, 32'h8, 1'b0},                      // R7 type
        '{32'h00200000, 32'h9, 32'ha, 3'd0, 32'h9, 32'ha, 1'b0},                      // R12 no transfer
        '{32'h00221020, 32'hb, 32'hc, 3'd2, 32'hb, 32'hc, 1'b0},                      // R7 regno range
        '{32'h002a07b0, 32'hd, 32'he, 3'd2, 32'hd, 32'he, 1'b0}                       // R7 postinc
    };

    initial begin
        logic [31:0] v;
        int          n0;
        for (int i = 0; i < 32; i++) gpr[i] = 64'(i) * 64'h0101;
        gpr[0] = '0;
        gpr[8] = 64'hffff8f80_00038220;
        dcsr_v = 64'h4000_0003;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 hart_req", {31'b0, hart_req}, 32'h0);
        dmi_rd(7'h16, v); check("R1 status", v, 32'h802);
        dmi_rd(7'h04, v); check("R1 data0", v, 32'h0);
        dmi_rd(7'h05, v); check("R1 data1", v, 32'h0);
        dmi_rd(7'h10, v); check("R3 unmapped", v, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            dmi_wr(7'h16, 32'h700);
            dmi_wr(7'h04, VT[i].pre0);
            dmi_wr(7'h05, VT[i].pre1);
            n0 = nreq;
            dmi_wr(7'h17, VT[i].cmd);
            wait_idle();
            dmi_rd(7'h16, v);
            check($sformatf("R2 status vec %0d", i), v, stat(1'b0, VT[i].err));
            dmi_rd(7'h04, v);
            check($sformatf("R4 data0 vec %0d", i), v, VT[i].exp0);
            dmi_rd(7'h05, v);
            check($sformatf("R5 data1 vec %0d", i), v, VT[i].exp1);
            check($sformatf("R13 request count vec %0d", i), 32'(nreq - n0), 32'(VT[i].req));
        end

        // R9 busy reporting and dropped data write
        dmi_wr(7'h16, 32'h700);
        dmi_wr(7'h17, 32'h002207b0);
        dmi_rd(7'h16, v); check("R9 busy visible", v, stat(1'b1, 3'd0));
        dmi_wr(7'h04, 32'h5555);
        wait_idle();
        dmi_rd(7'h16, v); check("R9 busy violation code", v, stat(1'b0, 3'd1));
        dmi_rd(7'h04, v); check("R9 data write dropped", v, 32'h40000003);

        // R10 command ignored while error pending
        dmi_wr(7'h04, 32'h0);
        n0 = nreq;
        dmi_wr(7'h17, 32'h002207b0);
        repeat (3) dmi_rd(7'h16, v);
        check("R10 status", v, stat(1'b0, 3'd1));
        dmi_rd(7'h04, v); check("R10 data0 untouched", v, 32'h0);
        check("R10 no request", 32'(nreq - n0), 32'h0);

        // R11 partial clearing
        dmi_wr(7'h16, 32'h100);
        dmi_rd(7'h16, v); check("R11 clear bit0", v, 32'h802);
        dmi_wr(7'h17, 32'h002207b5);
        wait_idle();
        dmi_rd(7'h16, v); check("R8 fault code", v, stat(1'b0, 3'd3));
        dmi_wr(7'h16, 32'h100);
        dmi_rd(7'h16, v); check("R11 partial 3->2", v, stat(1'b0, 3'd2));
        dmi_wr(7'h16, 32'h200);
        dmi_rd(7'h16, v); check("R11 cleared", v, 32'h802);

        // R3 op 0 does nothing
        dmi_valid = 1'b1; dmi_op = 2'd0; dmi_addr = 7'h04; dmi_wdata = 32'hffff_ffff;
        @(posedge clk); @(negedge clk);
        dmi_valid = 1'b0;
        dmi_rd(7'h04, v); check("R3 nop op", v, 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R13 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule